// File: doc/BRIEF.md
# Token-Ring Cascaded FIFO

This block builds one deep first-in/first-out buffer out of several identical shallow storage slices. All slices share one write strobe, one read strobe, one write data bus and one read data bus. Writing and reading need no addresses: each slice keeps its own write and read position. Two one-hot tokens travel around a ring of slices and decide which slice acts on each strobe. The write token and the read token move separately.

When the slice holding the write token stores into its last physical location, it passes the write token to the next slice in the ring. That slice then writes next into its own location zero. The read token moves in the same way on a read from the last physical location, and the last slice hands each token back to the first. An active-low first-load vector selects the slice that holds both tokens after reset. The buffer reports full only when every slice is full, and empty only when every slice is empty. Total capacity is the slice count times the slice depth.

Top module: `cascade_fifo`

## Requirements
- R1: While `rst_n` is low, every slice is cleared to location zero and holds no data. After reset, `empty` is 1 and `full` is 0.
- R2: Words leave in the order they were accepted, across every slice boundary. The word for an accepted read appears on `rd_data` after the clock edge that accepts the read.
- R3: With no reads, `full` rises after exactly SLICES*SLICE_DEPTH accepted writes and not before.
- R4: A write strobe while `full` is 1 is ignored: no word is stored and nothing already stored is lost.
- R5: A read strobe while `empty` is 1 is ignored: `rd_data` keeps its value and no position moves.
- R6: Exactly one slice holds the write token. It passes to the next slice, and from the last slice back to the first, only on a write to the last physical location.
- R7: Exactly one slice holds the read token. It passes around the ring only on a read from the last physical location.
- R8: The slice whose `first_load_n` bit is 0 during reset holds both tokens after reset. Order and capacity do not depend on which slice starts. Exactly one bit of `first_load_n` must be 0.
- R9: A write and a read in the same cycle are both accepted when the buffer is neither full nor empty. When it is empty, only the write is accepted; when it is full, only the read is accepted.
- R10: `full` and `empty` each equal the AND of the matching per-slice flags, and they are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| first_load_n | input | SLICES | Active-low start-slice select, sampled during reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WIDTH | Registered word last read |
| full | output | 1 | Every slice is full |
| empty | output | 1 | Every slice is empty |

## Verification
A short burst of writes and reads separates correct ordering from a mux that selects the wrong slice. A fill to capacity, followed by a drain, sends both tokens through every hand-off, including the wrap from the last slice to the first. It also shows whether writes made while full are really dropped. Long stretches of simultaneous reads and writes at several fill levels make the two tokens sit in different slices, which catches any coupling between them. A second reset with a different start slice checks that order and capacity do not change.

// File: rtl/cascade_fifo.sv
module cascade_fifo #(
  parameter int WIDTH       = 9,
  parameter int SLICES      = 4,
  parameter int SLICE_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLICES-1:0] first_load_n,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en,
  output logic [WIDTH-1:0]  rd_data,
  output logic              full,
  output logic              empty
);
  localparam int AW = (SLICE_DEPTH > 1) ? $clog2(SLICE_DEPTH) : 1;
  localparam int CW = $clog2(SLICE_DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(SLICE_DEPTH - 1);

  logic [SLICES-1:0] wtok, rtok, w_xo, r_xo, s_full, s_empty;
  logic [WIDTH-1:0]  slice_q [SLICES];
  logic [WIDTH-1:0]  q_sel;

  wire wr_go = wr_en & ~full;
  wire rd_go = rd_en & ~empty;

  assign full  = &s_full;
  assign empty = &s_empty;

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    localparam int PREV = (i + SLICES - 1) % SLICES;
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             wt, rt;
    logic [WIDTH-1:0] mem [SLICE_DEPTH];

    wire we = wr_go & wt;
    wire re = rd_go & rt;

    assign wtok[i]    = wt;
    assign rtok[i]    = rt;
    assign w_xo[i]    = we && (wp == LAST);
    assign r_xo[i]    = re && (rp == LAST);
    assign s_full[i]  = (cnt == CW'(SLICE_DEPTH));
    assign s_empty[i] = (cnt == '0);
    assign slice_q[i] = mem[rp];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
        wt  <= ~first_load_n[i];
        rt  <= ~first_load_n[i];
      end else begin
        if (w_xo[PREV])   wt <= 1'b1;
        else if (w_xo[i]) wt <= 1'b0;
        if (r_xo[PREV])   rt <= 1'b1;
        else if (r_xo[i]) rt <= 1'b0;
        if (we) wp <= (wp == LAST) ? '0 : wp + 1'b1;
        if (re) rp <= (rp == LAST) ? '0 : rp + 1'b1;
        if (we && !re)      cnt <= cnt + 1'b1;
        else if (re && !we) cnt <= cnt - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (we) mem[wp] <= wr_data;
    end
  end

  always_comb begin
    q_sel = '0;
    for (int k = 0; k < SLICES; k++)
      if (rtok[k]) q_sel = q_sel | slice_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_go) rd_data <= q_sel;
  end
endmodule

// File: rtl/cascade_fifo_chk.sv
module cascade_fifo_chk #(
  parameter int WIDTH  = 9,
  parameter int SLICES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic              full,
  input logic              empty,
  input logic [WIDTH-1:0]  rd_data,
  input logic [SLICES-1:0] wtok,
  input logic [SLICES-1:0] rtok
);
  p_wtok_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wtok) == 1);
  p_rtok_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rtok) == 1);
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  p_full_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> full);
  p_empty_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en) |=> (empty && $stable(rd_data)));
  p_rw_at_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && wr_en) |=> (!empty && $stable(rd_data)));
endmodule

bind cascade_fifo cascade_fifo_chk #(.WIDTH(WIDTH), .SLICES(SLICES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .full(full),
  .empty(empty), .rd_data(rd_data), .wtok(wtok), .rtok(rtok)
);

// File: tb/cascade_fifo_tb_top.sv
`timescale 1ns/1ps
module cascade_fifo_tb_top;
  localparam int W = 9, N = 4, D = 8, CAP = N * D;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] first_load_n = 4'b1110;
  logic wr_en = 0, rd_en = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic full, empty;

  cascade_fifo #(.WIDTH(W), .SLICES(N), .SLICE_DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  logic [W-1:0] ref_q[$];
  logic [W-1:0] exp_q[$];
  logic [W-1:0] last_exp = '0;
  logic chk_pend = 0, stay_pend = 0;
  int cnt = 0;
  logic [W-1:0] seed = 9'h05a;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always begin
    @(posedge clk); #2;
    if (chk_pend) begin
      logic [W-1:0] e;
      e = exp_q.pop_front();
      check(rd_data == e, tag, rd_data, e);
    end
    if (stay_pend) check(rd_data == last_exp, "R5", rd_data, last_exp);
  end

  task automatic step(input bit w, input bit r);
    bit wacc, racc;
    logic [W-1:0] d;
    @(negedge clk);
    d = seed; seed = seed * 9'd5 + 9'd3;
    wacc = w && (cnt < CAP);
    racc = r && (cnt > 0);
    wr_en = w; rd_en = r; wr_data = d;
    if (racc) begin
      last_exp = ref_q.pop_front();
      exp_q.push_back(last_exp);
    end
    if (wacc) ref_q.push_back(d);
    cnt = cnt + int'(wacc) - int'(racc);
    chk_pend = racc;
    stay_pend = r && !racc;
    @(posedge clk); #3;
    check(full == (cnt == CAP), "R3 R10 full", full, cnt == CAP);
    check(empty == (cnt == 0), "R10 empty", empty, cnt == 0);
    chk_pend = 0; stay_pend = 0;
    wr_en = 0; rd_en = 0;
  endtask

  task automatic do_reset(input logic [N-1:0] fl);
    @(negedge clk);
    rst_n = 0; first_load_n = fl;
    repeat (3) @(negedge clk);
    rst_n = 1;
    ref_q.delete(); exp_q.delete(); cnt = 0; last_exp = '0;
    #1;
    check(empty === 1'b1, "R1 empty", empty, 1);
    check(full === 1'b0, "R1 full", full, 0);
    check(rd_data === '0, "R1 data", rd_data, 0);
  endtask

  task automatic fill_drain();
    tag = "R3";
    for (int i = 0; i < CAP; i++) begin
      step(1, 0);
      if (i == CAP - 2) check(!full, "R3 early", full, 0);
    end
    tag = "R4";
    for (int i = 0; i < 3; i++) step(1, 0);
    tag = "R6 R7 R2";
    for (int i = 0; i < CAP; i++) step(0, 1);
  endtask

  initial begin
    #20000;
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset(4'b1110);
    tag = "R2";
    for (int i = 0; i < 5; i++) step(1, 0);
    for (int i = 0; i < 5; i++) step(0, 1);
    tag = "R5";
    step(0, 1); step(0, 1);
    fill_drain();
    tag = "R9";
    step(1, 1);
    for (int i = 0; i < 10; i++) step(1, 0);
    for (int i = 0; i < 60; i++) step(1, 1);
    for (int i = 0; i < 22; i++) step(1, 0);
    for (int i = 0; i < 40; i++) step(1, 1);
    for (int i = 0; i < 5; i++) step(i[0], 1);
    while (cnt > 0) step(0, 1);
    tag = "R8";
    do_reset(4'b1011);
    for (int i = 0; i < 13; i++) step(1, 0);
    for (int i = 0; i < 30; i++) step(1, 1);
    while (cnt > 0) step(0, 1);
    fill_drain();
    tag = "R1";
    for (int i = 0; i < 7; i++) step(1, 0);
    do_reset(4'b0111);
    tag = "R8";
    for (int i = 0; i < 20; i++) step(1, i > 9);
    while (cnt > 0) step(0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule